// File: doc/BRIEF.md
# Linked-List Transmit DMA with Packet Status Counters

This block is the transmit side of a simple Ethernet MAC's DMA. It also holds the status and interrupt logic that transmit and receive share. Software builds a chain of three-word descriptors in memory, writes the head pointer, and sets the DMA go bit. The engine then walks the chain. For each descriptor that holds a frame, it streams the payload bytes out one per cycle, hands the descriptor back by setting its empty flag, and follows the next pointer. The first descriptor that is already empty ends the walk: the engine flags underrun and drops the go bit.

When loopback is enabled, frames leave on a separate loopback stream, which feeds the receive path, and not on the transmit stream. Each direction keeps an 8-bit packet counter. Software acknowledges one packet at a time by writing a one, so every acknowledge retires exactly one counted packet. An interrupt line reports any status bit that software has unmasked.

Top module: `txlink_dma`

## Requirements
- R1: A walk starts only when a write to the DMA control register sets bit 0 while config bit 0 (transmit enable) is set and no walk is running. If transmit enable is clear, no memory request is made, and the control register still reads back the written value.
- R2: A descriptor at pointer P holds the buffer byte address at P+0, the control word at P+4 (bit 31 = empty, bits [10:0] = byte count) and the next pointer at P+8. Memory words are little-endian: the byte at the lowest address sits in bits [7:0]. A memory request holds its address and write data until ready is seen.
- R3: When the control word of the current descriptor has bit 31 set, the walk stops without writing that descriptor. Transmit status bit 1 (underrun) becomes set and DMA control bit 0 becomes clear.
- R4: A descriptor with a frame streams its byte count of bytes in ascending address order from the buffer address, which may be unaligned. The last flag is raised with the final byte. A count of zero streams nothing.
- R5: After its bytes are streamed, the descriptor's control word is written back with bit 31 set and its other bits unchanged, and the walk continues at the next pointer.
- R6: Each handed-back descriptor adds one to the transmit count (status bits [23:16]) and sets transmit status bit 0. A pulse on `rx_frame_evt` does the same in the receive status register. A pulse on `rx_ovf_evt` sets receive status bit 2.
- R7: Writing 1 to status bit 0 subtracts one from that register's count, and bit 0 clears when the count reaches zero. Writing 1 to transmit bit 1 or receive bit 2 clears that bit. Bits written as 0 have no effect.
- R8: When a count increment and an acknowledge fall in the same cycle, the count stays unchanged.
- R9: While config bit 8 (loopback) is set at the start of a frame, that frame appears on the loopback stream, and the transmit stream stays idle.
- R10: The interrupt vector is {receive status[3:0], transmit status[3:0]} ANDed with the mask register bits [7:0]. It is readable, and `irq` is high exactly when the vector is non-zero.
- R11: Writing the config register with bit 31 set aborts any walk and returns every register to its reset value: config reads 0x8000_0000 and all other registers read 0.
- R12: Bits [1:0] of the descriptor pointer register always read as zero.
- R13: The register word addresses are: 0 config, 1 DMA control, 2 descriptor pointer, 3 transmit status, 4 receive status, 5 interrupt mask, 6 interrupt vector. The vector is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory access completes this cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a transmit frame |
| lb_valid | output | 1 | Loopback byte valid |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final byte of a loopback frame |
| rx_frame_evt | input | 1 | Receive path stored one frame |
| rx_ovf_evt | input | 1 | Receive path overflowed |
| irq | output | 1 | Masked interrupt |

## Verification
The walker is exercised with four kinds of chain. A single aligned frame gives the baseline byte order. A three-descriptor chain with unaligned buffers, a zero-length entry and memory wait states checks lane selection, word-boundary crossing and address holding under latency. An empty head descriptor separates the stop path from the streaming path. A loopback frame shows that the output is routed by mode, not by data. For the counters, acknowledges are issued alone and in the same cycle as an increment, which distinguishes decrement-on-acknowledge from clear-on-acknowledge and tests the simultaneous-event rule. Soft reset is applied in the middle of a frame to show that the walk is abandoned as well as the registers cleared.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] A_DMA  = 3'd1;
  localparam logic [REG_AW-1:0] A_PTR  = 3'd2;
  localparam logic [REG_AW-1:0] A_TXS  = 3'd3;
  localparam logic [REG_AW-1:0] A_RXS  = 3'd4;
  localparam logic [REG_AW-1:0] A_MASK = 3'd5;
  localparam logic [REG_AW-1:0] A_VEC  = 3'd6;

  localparam int CFG_TXEN  = 0;
  localparam int CFG_LOOP  = 8;
  localparam int CFG_SRST  = 31;
  localparam logic [31:0] CFG_DEFAULT = 32'h8000_0000;

  localparam int EMPTY_BIT = 31;

  typedef enum logic [2:0] {
    W_IDLE, W_SIZE, W_ADDR, W_NEXT, W_FETCH, W_SEND, W_BACK
  } wstate_t;

  // Interrupt vector: receive nibble above transmit nibble, then masked.
  function automatic logic [7:0] irq_vector(input logic [31:0] txs,
                                            input logic [31:0] rxs,
                                            input logic [7:0]  mask);
    return {rxs[3:0], txs[3:0]} & mask;
  endfunction
endpackage

// File: rtl/txl_stat.sv
module txl_stat #(
  parameter int CNTW    = 8,
  parameter int ERR_POS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        inc,
  input  logic        err_set,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] stat
);
  logic [CNTW-1:0] cnt;
  logic            pkt;
  logic            err;
  logic            ack;
  logic            err_ack;
  logic [CNTW-1:0] cnt_nx;

  function automatic logic [CNTW-1:0] cnt_step(input logic [CNTW-1:0] c,
                                               input logic up,
                                               input logic dn);
    if (up && !dn) return c + 1'b1;
    if (dn && !up) return c - 1'b1;
    return c;
  endfunction

  assign ack     = wr && wdata[0];
  assign err_ack = wr && wdata[ERR_POS];
  assign cnt_nx  = cnt_step(cnt, inc, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pkt <= 1'b0;
      err <= 1'b0;
    end else if (soft_rst) begin
      cnt <= '0;
      pkt <= 1'b0;
      err <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (inc)                       pkt <= 1'b1;
      else if (ack && cnt_nx == '0)  pkt <= 1'b0;
      if (err_set)      err <= 1'b1;
      else if (err_ack) err <= 1'b0;
    end
  end

  always_comb begin
    stat             = '0;
    stat[16 +: CNTW] = cnt;
    stat[ERR_POS]    = err;
    stat[0]          = pkt;
  end

  // R8: increment and acknowledge together leave the count as it was
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && ack && !soft_rst) |=> (stat[16 +: CNTW] == $past(cnt)));

  // R7: acknowledging the last counted packet drops the packet bit
  p_pkt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !inc && !soft_rst && cnt == 1) |=> !stat[0]);
endmodule

// File: rtl/txl_walker.sv
module txl_walker
  import txl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          cfg_loop,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          lb_valid,
  output logic [7:0]    lb_data,
  output logic          lb_last,
  output logic          frame_done,
  output logic          chain_end
);
  wstate_t         st;
  logic [AW-1:0]   desc_ptr;
  logic [AW-1:0]   next_ptr;
  logic [AW-1:0]   buf_addr;
  logic [LENW-1:0] remain;
  logic [31:0]     ctrl_word;
  logic [31:0]     word_buf;
  logic            lb_sel;
  logic            xfer;
  logic            sending;
  logic            final_byte;
  logic [7:0]      cur_byte;

  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_NEXT = AW'(8);

  assign busy       = (st != W_IDLE);
  assign xfer       = mem_req && mem_ready;
  assign sending    = (st == W_SEND);
  assign final_byte = (remain == LENW'(1));
  assign cur_byte   = word_buf[{buf_addr[1:0], 3'b000} +: 8];
  assign chain_end  = (st == W_SIZE) && xfer && mem_rdata[EMPTY_BIT];
  assign frame_done = (st == W_BACK) && xfer;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = ctrl_word | (32'd1 << EMPTY_BIT);
    unique case (st)
      W_SIZE:  begin mem_req = 1'b1; mem_addr = desc_ptr + OFS_CTRL; end
      W_ADDR:  begin mem_req = 1'b1; mem_addr = desc_ptr; end
      W_NEXT:  begin mem_req = 1'b1; mem_addr = desc_ptr + OFS_NEXT; end
      W_FETCH: begin mem_req = 1'b1; mem_addr = {buf_addr[AW-1:2], 2'b00}; end
      W_BACK:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_ptr + OFS_CTRL; end
      default: ;
    endcase
  end

  assign tx_valid = sending && !lb_sel;
  assign lb_valid = sending && lb_sel;
  assign tx_data  = tx_valid ? cur_byte : 8'h00;
  assign lb_data  = lb_valid ? cur_byte : 8'h00;
  assign tx_last  = tx_valid && final_byte;
  assign lb_last  = lb_valid && final_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      desc_ptr  <= '0;
      next_ptr  <= '0;
      buf_addr  <= '0;
      remain    <= '0;
      ctrl_word <= '0;
      word_buf  <= '0;
      lb_sel    <= 1'b0;
    end else if (soft_rst) begin
      st <= W_IDLE;
    end else begin
      unique case (st)
        W_IDLE: if (start) begin
          desc_ptr <= start_ptr;
          st       <= W_SIZE;
        end
        W_SIZE: if (xfer) begin
          ctrl_word <= mem_rdata;
          remain    <= mem_rdata[LENW-1:0];
          st        <= mem_rdata[EMPTY_BIT] ? W_IDLE : W_ADDR;
        end
        W_ADDR: if (xfer) begin
          buf_addr <= mem_rdata[AW-1:0];
          lb_sel   <= cfg_loop;
          st       <= W_NEXT;
        end
        W_NEXT: if (xfer) begin
          next_ptr <= {mem_rdata[AW-1:2], 2'b00};
          st       <= (remain == '0) ? W_BACK : W_FETCH;
        end
        W_FETCH: if (xfer) begin
          word_buf <= mem_rdata;
          st       <= W_SEND;
        end
        W_SEND: begin
          buf_addr <= buf_addr + 1'b1;
          remain   <= remain - 1'b1;
          if (final_byte)               st <= W_BACK;
          else if (buf_addr[1:0] == 2'd3) st <= W_FETCH;
        end
        W_BACK: if (xfer) begin
          desc_ptr <= next_ptr;
          st       <= W_SIZE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R2: a pending access keeps its address until memory accepts it
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !soft_rst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5: the final streamed byte is followed by the hand-back write
  p_last_then_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_last || lb_last) && !soft_rst) |=> (mem_req && mem_we && mem_wdata[EMPTY_BIT]));

  // R9: a byte never appears on both streams
  p_one_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, lb_valid}));
endmodule

// File: rtl/txlink_dma.sv
module txlink_dma
  import txl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 11,
  parameter int CNTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              lb_valid,
  output logic [7:0]        lb_data,
  output logic              lb_last,
  input  logic              rx_frame_evt,
  input  logic              rx_ovf_evt,
  output logic              irq
);
  localparam int NDIR = 2;

  logic [31:0]   cfg_q;
  logic [31:0]   dma_q;
  logic [AW-1:0] ptr_q;
  logic [7:0]    mask_q;
  logic          soft_rst;
  logic          start;
  logic          walk_busy;
  logic          frame_done;
  logic          chain_end;
  logic [7:0]    vec;
  logic [NDIR-1:0] ev_inc;
  logic [NDIR-1:0] ev_err;
  logic [NDIR-1:0] ev_wr;
  logic [31:0]   stat_w [NDIR];

  assign soft_rst = reg_wr && (reg_addr == A_CFG) && reg_wdata[CFG_SRST];
  assign start    = reg_wr && (reg_addr == A_DMA) && reg_wdata[0] &&
                    cfg_q[CFG_TXEN] && !walk_busy && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      dma_q  <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      cfg_q  <= CFG_DEFAULT;
      dma_q  <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG)  cfg_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_PTR)  ptr_q  <= {reg_wdata[AW-1:2], 2'b00};
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[7:0];
      if (chain_end)
        dma_q <= (reg_wr && reg_addr == A_DMA) ? {reg_wdata[31:1], 1'b0}
                                               : {dma_q[31:1], 1'b0};
      else if (reg_wr && reg_addr == A_DMA)
        dma_q <= reg_wdata;
    end
  end

  txl_walker #(.AW(AW), .LENW(LENW)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .start      (start),
    .start_ptr  (ptr_q),
    .cfg_loop   (cfg_q[CFG_LOOP]),
    .busy       (walk_busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .lb_valid   (lb_valid),
    .lb_data    (lb_data),
    .lb_last    (lb_last),
    .frame_done (frame_done),
    .chain_end  (chain_end)
  );

  assign ev_inc = {rx_frame_evt, frame_done};
  assign ev_err = {rx_ovf_evt, chain_end};
  assign ev_wr  = {reg_wr && reg_addr == A_RXS, reg_wr && reg_addr == A_TXS};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    txl_stat #(.CNTW(CNTW), .ERR_POS(g == 0 ? 1 : 2)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .inc      (ev_inc[g]),
      .err_set  (ev_err[g]),
      .wr       (ev_wr[g]),
      .wdata    (reg_wdata),
      .stat     (stat_w[g])
    );
  end

  assign vec = irq_vector(stat_w[0], stat_w[1], mask_q);
  assign irq = |vec;

  always_comb begin
    unique case (reg_addr)
      A_CFG:   reg_rdata = cfg_q;
      A_DMA:   reg_rdata = dma_q;
      A_PTR:   reg_rdata = 32'(ptr_q);
      A_TXS:   reg_rdata = stat_w[0];
      A_RXS:   reg_rdata = stat_w[1];
      A_MASK:  reg_rdata = {24'd0, mask_q};
      A_VEC:   reg_rdata = {24'd0, vec};
      default: reg_rdata = '0;
    endcase
  end

  // R3: reaching an empty descriptor flags underrun and drops the go bit
  p_end_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_end && !soft_rst) |=> (stat_w[0][1] && !dma_q[0]));

  // R1: with transmit enable clear an idle walker stays idle
  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!walk_busy && !cfg_q[CFG_TXEN]) |=> !walk_busy);

  // R10: a cleared mask keeps the interrupt low
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'd0) |-> !irq);

  // R11: soft reset leaves the walker idle on the next cycle
  p_soft_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!mem_req && !tx_valid && !lb_valid));
endmodule

// File: tb/txlink_dma_bench.sv
module txlink_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, lb_valid, lb_last;
  logic [7:0]  tx_data, lb_data;
  logic        rx_frame_evt = 1'b0;
  logic        rx_ovf_evt = 1'b0;
  logic        irq;

  always #10 clk = ~clk;

  txlink_dma u_txlink_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .lb_valid(lb_valid),
    .lb_data(lb_data), .lb_last(lb_last), .rx_frame_evt(rx_frame_evt),
    .rx_ovf_evt(rx_ovf_evt), .irq(irq)
  );

  // Memory model: 256 words, little-endian bytes, programmable wait states
  logic [31:0] mem [0:255];
  int          lat = 0;
  int          wcnt = 0;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = mem_req && (wcnt >= lat);
  always @(posedge clk) begin
    if (!mem_req || mem_ready) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
  end

  // Stream capture
  logic [7:0] cap_tx [0:255];
  logic [7:0] cap_lb [0:255];
  int ntx = 0, nlb = 0, ftx = 0, flb = 0, nreq = 0;
  always @(posedge clk) begin
    if (tx_valid) begin cap_tx[ntx[7:0]] = tx_data; ntx++; if (tx_last) ftx++; end
    if (lb_valid) begin cap_lb[nlb[7:0]] = lb_data; nlb++; if (lb_last) flb++; end
    if (mem_req) nreq++;
  end

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    @(negedge clk);
    ntx = 0; nlb = 0; ftx = 0; flb = 0; nreq = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    mem[a[9:2]][8*a[1:0] +: 8] = b;
  endtask

  task automatic put_desc(input int p, input logic [31:0] b, input logic [31:0] c,
                          input logic [31:0] n);
    mem[p[9:2]] = b; mem[(p+4) >> 2] = c; mem[(p+8) >> 2] = n;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd1, d);
      if (!d[0]) return;
    end
    check("R3 walk did not end", 32'd1, 32'd0);
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'(f * 37 + i * 5 + 1);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R13 cfg reset", d, 32'h8000_0000);
    for (int a = 1; a < 7; a++) begin
      rd(3'(a), d); check("R13 reg reset zero", d, 32'd0);
    end
    check("R10 irq at reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_ptr_align();
    logic [31:0] d;
    wr(3'd2, 32'h0000_1237);
    rd(3'd2, d); check("R12 pointer low bits", d, 32'h0000_1234);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    put_desc('h100, 32'h200, 32'd4, 32'h110);
    wr(3'd0, 32'h0); wr(3'd2, 32'h100);
    clr_cap();
    wr(3'd1, 32'h1);
    repeat (20) @(negedge clk);
    check("R1 no request when tx disabled", nreq, 0);
    rd(3'd1, d); check("R1 dma reg holds written value", d, 32'h1);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    lat = 0;
    for (int i = 0; i < 5; i++) put_byte('h200 + i, pat(0, i));
    put_desc('h100, 32'h200, 32'h0000_0005, 32'h110);
    mem['h114 >> 2] = 32'h8000_0000;
    wr(3'd0, 32'h1); wr(3'd2, 32'h100);
    clr_cap();
    wr(3'd1, 32'h1);
    wait_idle();
    check("R4 single frame length", ntx, 5);
    check("R4 single frame count", ftx, 1);
    for (int i = 0; i < 5; i++) check("R2 R4 byte order", cap_tx[i], pat(0, i));
    check("R5 control handed back", mem['h104 >> 2], 32'h8000_0005);
    check("R3 empty descriptor not written", mem['h114 >> 2], 32'h8000_0000);
    rd(3'd3, d); check("R6 R3 tx status after one frame", d, 32'h0001_0003);
    wr(3'd3, 32'h3);
    rd(3'd3, d); check("R7 ack to zero clears bits", d, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int k;
    lat = 2;
    for (int i = 0; i < 7; i++) put_byte('h301 + i, pat(1, i));
    for (int i = 0; i < 3; i++) put_byte('h343 + i, pat(2, i));
    put_desc('h120, 32'h301, 32'h0001_0007, 32'h130);
    put_desc('h130, 32'h380, 32'h0000_0000, 32'h141);
    put_desc('h140, 32'h343, 32'h0000_0003, 32'h150);
    mem['h154 >> 2] = 32'h8000_0000;
    wr(3'd2, 32'h120);
    clr_cap();
    wr(3'd1, 32'h1);
    wait_idle();
    check("R4 zero-count entry streams nothing", ftx, 2);
    check("R4 chain byte total", ntx, 10);
    k = 0;
    for (int i = 0; i < 7; i++) begin check("R2 R4 unaligned bytes", cap_tx[k], pat(1, i)); k++; end
    for (int i = 0; i < 3; i++) begin check("R4 word-crossing bytes", cap_tx[k], pat(2, i)); k++; end
    check("R5 upper bits kept", mem['h124 >> 2], 32'h8001_0007);
    check("R5 zero entry handed back", mem['h134 >> 2], 32'h8000_0000);
    check("R5 next pointer followed", mem['h144 >> 2], 32'h8000_0003);
    rd(3'd3, d); check("R6 three frames counted", d, 32'h0003_0003);
    wr(3'd3, 32'h1);
    rd(3'd3, d); check("R7 ack decrements only", d, 32'h0002_0003);
    wr(3'd3, 32'h2);
    rd(3'd3, d); check("R7 underrun ack", d, 32'h0002_0001);
    wr(3'd3, 32'h1); wr(3'd3, 32'h1);
    rd(3'd3, d); check("R7 packet bit clears at zero", d, 32'h0);
    lat = 0;
  endtask

  task automatic t_loop();
    for (int i = 0; i < 4; i++) put_byte('h3c0 + i, pat(3, i));
    put_desc('h160, 32'h3c0, 32'd4, 32'h170);
    mem['h174 >> 2] = 32'h8000_0000;
    wr(3'd0, 32'h101); wr(3'd2, 32'h160);
    clr_cap();
    wr(3'd1, 32'h1);
    wait_idle();
    check("R9 transmit stream idle in loopback", ntx, 0);
    check("R9 loopback frame", flb, 1);
    for (int i = 0; i < 4; i++) check("R9 loopback bytes", cap_lb[i], pat(3, i));
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h3);
  endtask

  task automatic t_rx_ack();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_frame_evt = 1'b1;
      @(negedge clk); rx_frame_evt = 1'b0;
    end
    rd(3'd4, d); check("R6 rx count", d, 32'h0003_0001);
    @(negedge clk);
    rx_frame_evt = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
    @(negedge clk);
    rx_frame_evt = 1'b0; reg_wr = 1'b0; reg_wdata = 32'h0;
    rd(3'd4, d); check("R8 simultaneous inc and ack", d, 32'h0003_0001);
    wr(3'd4, 32'h0);
    rd(3'd4, d); check("R7 zero write no effect", d, 32'h0003_0001);
    @(negedge clk); rx_ovf_evt = 1'b1;
    @(negedge clk); rx_ovf_evt = 1'b0;
    rd(3'd4, d); check("R6 overflow bit", d, 32'h0003_0005);
    wr(3'd4, 32'h4);
    rd(3'd4, d); check("R7 overflow ack", d, 32'h0003_0001);
    wr(3'd4, 32'h1); wr(3'd4, 32'h1);
    rd(3'd4, d); check("R7 rx one left", d, 32'h0001_0001);
  endtask

  task automatic t_irq_empty();
    logic [31:0] d;
    mem['h184 >> 2] = 32'h8000_0033;
    wr(3'd2, 32'h180);
    clr_cap();
    wr(3'd1, 32'h1);
    wait_idle();
    check("R3 empty head streams nothing", ntx, 0);
    check("R3 empty head not written", mem['h184 >> 2], 32'h8000_0033);
    rd(3'd3, d); check("R3 underrun only", d, 32'h0000_0002);
    wr(3'd5, 32'h10);
    rd(3'd6, d); check("R10 rx nibble masked in", d, 32'h10);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h01);
    rd(3'd6, d); check("R10 vector masked out", d, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'hFF);
    wr(3'd6, 32'h0);
    rd(3'd6, d); check("R13 vector write ignored", d, 32'h12);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    lat = 3;
    for (int i = 0; i < 40; i++) put_byte('h200 + i, pat(4, i));
    put_desc('h190, 32'h200, 32'd40, 32'h1a0);
    wr(3'd2, 32'h190);
    wr(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    clr_cap();
    repeat (20) @(negedge clk);
    check("R11 walk aborted", nreq + ntx, 0);
    rd(3'd0, d); check("R11 cfg default", d, 32'h8000_0000);
    for (int a = 1; a < 7; a++) begin
      rd(3'(a), d); check("R11 register cleared", d, 32'd0);
    end
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_align();
    t_disabled();
    t_single();
    t_chain();
    t_loop();
    t_rx_ack();
    t_irq_empty();
    t_soft();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule